// File: doc/BRIEF.md
# Sequential Nearest-Neighbour Distance Engine

This block measures how far a query point in three-dimensional feature space lies from every point of a fixed reference set, one reference point per clock. A query made of three signed fixed-point features (signal power, mean-frequency ratio and frequency-change ratio, each with 10 fractional bits) is captured when a start pulse is accepted. An address counter then walks the internal reference table from the first entry to the last. One shared arithmetic unit forms the squared Euclidean distance for each entry, with all three features weighted equally.

Each result leaves the block as a distance paired with the one-hot class label of its reference entry, qualified by a valid strobe, in table order and on consecutive cycles. A downstream ranking stage consumes this stream. A one-cycle completion pulse marks the end of the stream. The square root is never taken, because ordering by squared distance gives the same neighbours. Intermediate widths are chosen so that no pair of signed 32-bit inputs can overflow.

The reference table holds 64 entries for each of three classes. Its contents are computed by a fixed rule, so the table needs no initialisation file.

Top module: `knn_dist_engine`

## Requirements
- R1: While reset is held, and after its release until a start is accepted, pairValid and done are low.
- R2: A start sampled high while idle begins a run of exactly 192 pairs, one per cycle with no gaps, for entries 0 to 191 in increasing order. The first pair is valid in the second cycle after the edge that accepted start.
- R3: pairDist equals (qAct-a)^2 + (qMob-m)^2 + (qCpx-c)^2 for the entry's features a, m, c. It is 66 bits wide and unsigned, and it is exact for every signed 32-bit query value, including the most negative and most positive.
- R4: pairClass is one-hot. Entries 0-63 carry 3'b001 (interictal), entries 64-127 carry 3'b010 (normal) and entries 128-191 carry 3'b100 (ictal).
- R5: For entry i, let g = i/64 and j = i%64. The features are a = g*16384 + j*256, m = j*40 + 100 and c = g*2048 + (j%8)*300, as raw 32-bit fixed-point values with 10 fractional bits.
- R6: done is high for exactly one cycle, the cycle right after the last pair, and never in the same cycle as pairValid.
- R7: A start raised at any time from acceptance until done is ignored. The run is neither restarted nor lengthened.
- R8: The query inputs are sampled only at the accepting edge. Changing them during a run has no effect on any pair.
- R9: A start sampled in the cycle where done is high is accepted, and a new run follows with the same timing as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a run |
| qAct | input | 32 | Query feature 0, signed fixed point |
| qMob | input | 32 | Query feature 1, signed fixed point |
| qCpx | input | 32 | Query feature 2, signed fixed point |
| pairValid | output | 1 | Qualifies pairDist and pairClass |
| pairDist | output | 66 | Squared distance to the current entry |
| pairClass | output | 3 | One-hot class of the current entry |
| done | output | 1 | Single-cycle end-of-run pulse |

## Verification
The assertions assume that start is a clean synchronous level and that the downstream sorter accepts one pair every cycle. The block has no back-pressure input, so the assertions place no condition on the consumer. The stimulus drives start and the query inputs only on the falling clock edge. The stimulus raises start while a run is in progress and changes the query inputs mid-run, to check that the assertions on run length and on the done timing still hold when an input is misused. The query vectors include the most negative and most positive 32-bit values, so the widest possible difference reaches the squaring logic.

// File: rtl/knn_pkg.sv
package knn_pkg;

  typedef struct packed {
    logic load;   // capture query this cycle
    logic issue;  // current address is being read
    logic last;   // current address is the final entry
  } ctrlStrobe_t;

  // Reference feature rule: g = group, j = index within group, k = feature
  function automatic int refFeature(input int idx, input int perGroup, input int k);
    int g;
    int j;
    g = idx / perGroup;
    j = idx % perGroup;
    case (k)
      0:       return g * 16384 + j * 256;
      1:       return j * 40 + 100;
      default: return g * 2048 + (j % 8) * 300;
    endcase
  endfunction

endpackage

// File: rtl/knn_ctrl.sv
module knn_ctrl
  import knn_pkg::*;
#(
  parameter int N_ENTRY = 192,
  localparam int ADDR_W = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              drainDone,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] addr
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;
  state_t state;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_ENTRY - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      addr  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          addr  <= '0;
        end
        S_RUN: begin
          if (addr == LAST_ADDR) state <= S_DRAIN;
          else                   addr  <= addr + 1'b1;
        end
        S_DRAIN: if (drainDone) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = (state == S_IDLE) && start;
    strobe.issue = (state == S_RUN);
    strobe.last  = (state == S_RUN) && (addr == LAST_ADDR);
  end

endmodule

// File: rtl/knn_dpath.sv
module knn_dpath
  import knn_pkg::*;
#(
  parameter int FEAT_W    = 32,
  parameter int N_CLASS   = 3,
  parameter int PER_CLASS = 64,
  localparam int N_ENTRY  = N_CLASS * PER_CLASS,
  localparam int ADDR_W   = $clog2(N_ENTRY),
  localparam int DIFF_W   = FEAT_W + 1,
  localparam int DIST_W   = 2 * FEAT_W + 2,
  localparam int N_FEAT   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [ADDR_W-1:0]        addr,
  input  logic signed [FEAT_W-1:0] qAct,
  input  logic signed [FEAT_W-1:0] qMob,
  input  logic signed [FEAT_W-1:0] qCpx,
  output logic                     pairValid,
  output logic [DIST_W-1:0]        pairDist,
  output logic [N_CLASS-1:0]       pairClass,
  output logic                     done,
  output logic                     lastOut
);

  logic signed [FEAT_W-1:0] qReg   [N_FEAT];
  logic signed [FEAT_W-1:0] qIn    [N_FEAT];
  logic signed [FEAT_W-1:0] refVal [N_FEAT];
  logic signed [DIFF_W-1:0] diffR  [N_FEAT];
  logic signed [DIST_W-1:0] sqTerm [N_FEAT];
  logic [N_CLASS-1:0]       classR;
  logic [N_CLASS-1:0]       classNow;
  logic                     v1, last1, v2, last2;

  assign qIn[0] = qAct;
  assign qIn[1] = qMob;
  assign qIn[2] = qCpx;

  always_comb begin
    classNow = '0;
    classNow[int'(addr) / PER_CLASS] = 1'b1;
  end

  for (genvar k = 0; k < N_FEAT; k++) begin : g_feat
    logic signed [DIST_W-1:0] diffExt;

    assign refVal[k] = FEAT_W'(refFeature(int'(addr), PER_CLASS, k));
    assign diffExt   = {{(DIST_W-DIFF_W){diffR[k][DIFF_W-1]}}, diffR[k]};
    assign sqTerm[k] = diffExt * diffExt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        qReg[k]  <= '0;
        diffR[k] <= '0;
      end else begin
        if (strobe.load) qReg[k] <= qIn[k];
        if (strobe.issue)
          diffR[k] <= DIFF_W'(qReg[k]) - DIFF_W'(refVal[k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1        <= 1'b0;
      last1     <= 1'b0;
      classR    <= '0;
      v2        <= 1'b0;
      last2     <= 1'b0;
      pairDist  <= '0;
      pairClass <= '0;
      done      <= 1'b0;
    end else begin
      v1    <= strobe.issue;
      last1 <= strobe.last;
      if (strobe.issue) classR <= classNow;
      v2    <= v1;
      last2 <= v1 && last1;
      if (v1) begin
        pairDist  <= $unsigned(sqTerm[0] + sqTerm[1] + sqTerm[2]);
        pairClass <= classR;
      end
      done <= v2 && last2;
    end
  end

  assign pairValid = v2;
  assign lastOut   = v2 && last2;

endmodule

// File: rtl/knn_dist_engine.sv
module knn_dist_engine
  import knn_pkg::*;
#(
  parameter int FEAT_W    = 32,
  parameter int N_CLASS   = 3,
  parameter int PER_CLASS = 64,
  localparam int N_ENTRY  = N_CLASS * PER_CLASS,
  localparam int ADDR_W   = $clog2(N_ENTRY),
  localparam int DIST_W   = 2 * FEAT_W + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic signed [FEAT_W-1:0] qAct,
  input  logic signed [FEAT_W-1:0] qMob,
  input  logic signed [FEAT_W-1:0] qCpx,
  output logic                     pairValid,
  output logic [DIST_W-1:0]        pairDist,
  output logic [N_CLASS-1:0]       pairClass,
  output logic                     done
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] addr;
  logic              lastOut;

  knn_ctrl #(.N_ENTRY(N_ENTRY)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .drainDone(lastOut),
    .strobe(strobe), .addr(addr)
  );

  knn_dpath #(.FEAT_W(FEAT_W), .N_CLASS(N_CLASS), .PER_CLASS(PER_CLASS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .qAct(qAct), .qMob(qMob), .qCpx(qCpx),
    .pairValid(pairValid), .pairDist(pairDist), .pairClass(pairClass),
    .done(done), .lastOut(lastOut)
  );

endmodule

// File: rtl/knn_dist_engine_chk.sv
module knn_dist_engine_chk #(
  parameter int N_CLASS   = 3,
  parameter int PER_CLASS = 64,
  localparam int N_ENTRY  = N_CLASS * PER_CLASS,
  localparam int CNT_W    = $clog2(N_ENTRY + 2)
) (
  input logic               clk,
  input logic               rstN,
  input logic               pairValid,
  input logic [N_CLASS-1:0] pairClass,
  input logic               done
);

  logic [CNT_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rstN)          seen <= '0;
    else if (done)      seen <= '0;
    else if (pairValid) seen <= seen + 1'b1;
  end

  // R4: each valid pair carries exactly one class bit
  a_r4_class_onehot: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> $onehot(pairClass));

  // R6: done never coincides with a pair
  a_r6_done_alone: assert property (@(posedge clk) disable iff (!rstN)
    !(done && pairValid));

  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: pairs are contiguous until the run ends
  a_r2_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> (pairValid || done));

  // R2, R7: a run delivers exactly the full table before done
  a_r7_full_run: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (seen == CNT_W'(N_ENTRY)));

  // R1: done is preceded by a pair
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(pairValid));

endmodule

bind knn_dist_engine knn_dist_engine_chk #(.N_CLASS(N_CLASS), .PER_CLASS(PER_CLASS)) u_chk (
  .clk(clk), .rstN(rstN), .pairValid(pairValid), .pairClass(pairClass), .done(done)
);

// File: tb/knn_dist_engine_tb.sv
module knn_dist_engine_tb;

  localparam int N_ENTRY = 192;
  localparam int PER     = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic signed [31:0] qAct = '0, qMob = '0, qCpx = '0;
  logic        pairValid;
  logic [65:0] pairDist;
  logic [2:0]  pairClass;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  knn_dist_engine u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .qAct(qAct), .qMob(qMob), .qCpx(qCpx),
    .pairValid(pairValid), .pairDist(pairDist), .pairClass(pairClass), .done(done)
  );

  // Query vectors: activity, mobility, complexity
  localparam int N_VEC = 5;
  localparam logic signed [31:0] VEC [N_VEC][3] = '{
    '{32'sd0,          32'sd0,          32'sd0},
    '{32'sd20000,      32'sd700,        32'sd1500},
    '{-32'sd5000,      -32'sd300,       -32'sd8000},
    '{32'sh7FFFFFFF,   32'sh80000000,   32'sh7FFFFFFF},
    '{32'sd30000,      32'sd1500,       32'sd4000}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Table rule from R5
  function automatic logic signed [65:0] featR5(input int i, input int k);
    int g = i / PER;
    int j = i % PER;
    if (k == 0) return 66'(g * 16384 + j * 256);
    if (k == 1) return 66'(j * 40 + 100);
    return 66'(g * 2048 + (j % 8) * 300);
  endfunction

  // Distance rule from R3
  function automatic logic [65:0] distR3(input int i, input logic signed [31:0] a,
                                         input logic signed [31:0] m, input logic signed [31:0] c);
    logic signed [65:0] q [3];
    logic signed [65:0] d;
    logic [65:0] s = '0;
    q[0] = a; q[1] = m; q[2] = c;
    for (int k = 0; k < 3; k++) begin
      d = q[k] - featR5(i, k);
      s = s + $unsigned(d * d);
    end
    return s;
  endfunction

  function automatic logic [2:0] classR4(input int i);
    return 3'b001 << (i / PER);
  endfunction

  task automatic kick(input logic signed [31:0] a, input logic signed [31:0] m,
                      input logic signed [31:0] c);
    @(negedge clk);
    start = 1'b1; qAct = a; qMob = m; qCpx = c;
  endtask

  // Called with start already high ahead of the accepting edge.
  // disturbAt >= 0: raise start and alter the query at that sample (R7, R8).
  // chain: raise start with the next query while done is high (R9).
  task automatic runCheck(input logic signed [31:0] a, input logic signed [31:0] m,
                          input logic signed [31:0] c, input int disturbAt,
                          input bit chain, input logic signed [31:0] na,
                          input logic signed [31:0] nm, input logic signed [31:0] nc);
    int cnt = 0;
    int lastN = -10;
    bit fin = 0;
    for (int n = 0; n < 400 && !fin; n++) begin
      @(negedge clk);
      if (n == 0) begin
        start = 1'b0;
        qAct = ~a; qMob = ~m; qCpx = ~c;  // R8: changes after acceptance
      end
      if (pairValid) begin
        check(n == cnt + 2, "R2", "pair timing", 66'(n), 66'(cnt + 2));
        if (cnt < N_ENTRY) begin
          check(pairDist == distR3(cnt, a, m, c), "R3", "distance",
                pairDist, distR3(cnt, a, m, c));
          check(pairClass == classR4(cnt), "R4", "class", 66'(pairClass), 66'(classR4(cnt)));
        end
        cnt++;
        lastN = n;
      end
      if (done) begin
        check(cnt == N_ENTRY, "R7", "pair count", 66'(cnt), 66'(N_ENTRY));
        check(lastN == n - 1 && !pairValid, "R6", "done placement", 66'(lastN), 66'(n - 1));
        fin = 1;
        if (chain) begin
          start = 1'b1; qAct = na; qMob = nm; qCpx = nc;
        end
      end else if (disturbAt >= 0 && n == disturbAt) begin
        start = 1'b1; qAct = 32'sd123456; qMob = -32'sd99; qCpx = 32'sd7;
      end else if (disturbAt >= 0 && n == disturbAt + 1) begin
        start = 1'b0;
      end
    end
    check(fin, "R6", "done seen", 66'(fin), 66'd1);
    if (!fin) start = 1'b0;
    if (!chain) begin
      // no further pairs after done
      repeat (3) begin
        @(negedge clk);
        check(!pairValid && !done, "R7", "idle after run", 66'(pairValid), 66'd0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!pairValid && !done, "R1", "outputs in reset", 66'({pairValid, done}), 66'd0);
    rstN = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(!pairValid && !done, "R1", "idle after reset", 66'({pairValid, done}), 66'd0);
    end

    // R2, R3, R4, R5: vector table
    for (int v = 0; v < N_VEC; v++) begin
      kick(VEC[v][0], VEC[v][1], VEC[v][2]);
      runCheck(VEC[v][0], VEC[v][1], VEC[v][2], -1, 1'b0, '0, '0, '0);
    end

    // R7, R8: start and new query during a run
    kick(32'sd40000, 32'sd2000, 32'sd3000);
    runCheck(32'sd40000, 32'sd2000, 32'sd3000, 50, 1'b0, '0, '0, '0);

    // R7: start held high near the end of a run
    kick(32'sd1, 32'sd2, 32'sd3);
    runCheck(32'sd1, 32'sd2, 32'sd3, 190, 1'b0, '0, '0, '0);

    // R9: back-to-back runs
    kick(32'sd16384, 32'sd500, 32'sd2048);
    runCheck(32'sd16384, 32'sd500, 32'sd2048, -1, 1'b1, -32'sd777, 32'sd2600, 32'sd600);
    runCheck(-32'sd777, 32'sd2600, 32'sd600, -1, 1'b0, '0, '0, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule